// File: doc/BRIEF.md
# Ratio-Window Spectral Sub-Trigger

This block decides, for one time bin, whether a set of spectral coefficients has a chosen spectral shape. Each coefficient is compared with a window whose edges are a reference coefficient multiplied by a lower and an upper scaled threshold. The block therefore tests the ratio of each coefficient to the reference without a divider. The thresholds are fixed point with `FRAC` fractional bits. The coefficient is shifted left by `FRAC` before the compare, so with a reference of 2^FRAC the window edges equal the thresholds in coefficient units.

Every coefficient that lies strictly inside its window raises a hit flag. The block counts the hits and compares the count with an occupancy level. The one-bit sub-trigger fires only if the count reaches that level and the veto-enable input is high. Occupancy and veto-enable are sampled in the same cycle as the coefficients and travel with them through the pipeline. A new vector can be accepted every cycle. The block does not compute the transform, the thresholds or the veto.

Top module: `ratio_window_subtrig`

## Requirements
- R1: Coefficient k is a hit when `ref*lo_k < coef_k*2^FRAC < ref*hi_k`, with all values signed two's complement and FRAC=8 by default.
- R2: `out_valid_o` follows `in_valid_i` exactly 3 clock cycles later, and the result in that cycle belongs to the inputs sampled 3 cycles earlier.
- R3: A coefficient exactly equal to its lower bound is not a hit.
- R4: A coefficient exactly equal to its upper bound is not a hit.
- R5: When the sampled `veto_en_i` is 0, `trig_o` stays 0 whatever the hit count.
- R6: `trig_o` is 1 only in cycles where `out_valid_o` is 1.
- R7: An occupancy of 0 makes `trig_o` 1 for every valid vector sampled with `veto_en_i` = 1, even when there are no hits.
- R8: With `veto_en_i` = 1, `trig_o` is 1 exactly when the hit count is greater than or equal to the 4-bit occupancy, read as unsigned.
- R9: Negative references, thresholds and coefficients are handled as signed values, so a negative reference turns the window around.
- R10: Vectors applied in consecutive cycles each produce their own result, with their own occupancy and veto-enable, in consecutive cycles.
- R11: While reset (`rst_n` = 0) is held, `out_valid_o` and `trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| ref_i | input | DW (18) | Signed reference coefficient |
| coef_i | input | N_COEF*DW (198) | Signed coefficients; coefficient k at bits [k*DW +: DW] |
| thr_lo_i | input | N_COEF*TW (198) | Signed lower scaled thresholds, same packing |
| thr_hi_i | input | N_COEF*TW (198) | Signed upper scaled thresholds, same packing |
| occ_i | input | OCC_W (4) | Occupancy level, unsigned |
| veto_en_i | input | 1 | Veto enable; 0 suppresses the sub-trigger |
| out_valid_o | output | 1 | Result valid |
| trig_o | output | 1 | Sub-trigger |

## Verification
The hardest cases to reach are the window edges, where a coefficient times 2^FRAC equals a product exactly. A difference of one bit decides whether the coefficient is a hit. The bench uses a reference of 2^FRAC so that each product equals its threshold in coefficient units. It then places coefficients on the bound, one above it and one below it, and sets the occupancy to the resulting count and to one more than that count. Back-to-back vectors with a different occupancy and veto-enable in each cycle show that these side inputs stay with their own data through the pipeline.

// File: rtl/ratio_window_subtrig.sv
module ratio_window_subtrig #(
  parameter int N_COEF = 11,
  parameter int DW     = 18,
  parameter int TW     = 18,
  parameter int FRAC   = 8,
  parameter int OCC_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid_i,
  input  logic signed [DW-1:0]   ref_i,
  input  logic [N_COEF*DW-1:0]   coef_i,
  input  logic [N_COEF*TW-1:0]   thr_lo_i,
  input  logic [N_COEF*TW-1:0]   thr_hi_i,
  input  logic [OCC_W-1:0]       occ_i,
  input  logic                   veto_en_i,
  output logic                   out_valid_o,
  output logic                   trig_o
);
  localparam int PW = DW + TW;

  logic                 v1, v2;
  logic                 ven1, ven2;
  logic [OCC_W-1:0]     occ1, occ2;
  logic [N_COEF-1:0]    hit2;
  int                   hits;

  logic signed [PW-1:0] lo_p  [N_COEF];
  logic signed [PW-1:0] hi_p  [N_COEF];
  logic signed [PW-1:0] cf_s1 [N_COEF];

  for (genvar k = 0; k < N_COEF; k++) begin : g_lane
    logic signed [DW-1:0] c;
    logic signed [TW-1:0] tl, th;
    assign c  = coef_i[k*DW +: DW];
    assign tl = thr_lo_i[k*TW +: TW];
    assign th = thr_hi_i[k*TW +: TW];

    always_ff @(posedge clk) begin
      lo_p[k]  <= ref_i * tl;
      hi_p[k]  <= ref_i * th;
      cf_s1[k] <= PW'(c) <<< FRAC;
    end

    always_ff @(posedge clk)
      hit2[k] <= (cf_s1[k] > lo_p[k]) && (cf_s1[k] < hi_p[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid_o <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      v1 <= in_valid_i;
      v2 <= v1;
      out_valid_o <= v2;
      trig_o <= v2 && ven2 && (hits >= int'(occ2));
    end
  end

  always_ff @(posedge clk) begin
    occ1 <= occ_i;
    ven1 <= veto_en_i;
    occ2 <= occ1;
    ven2 <= ven1;
  end

  always_comb begin
    hits = 0;
    for (int k = 0; k < N_COEF; k++) hits += int'(hit2[k]);
  end
endmodule

// File: rtl/ratio_window_subtrig_chk.sv
module ratio_window_subtrig_chk #(
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic [OCC_W-1:0] occ_i,
  input logic             veto_en_i,
  input logic             out_valid_o,
  input logic             trig_o
);
  logic [2:0] vh, eh, zh;
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vh <= '0; eh <= '0; zh <= '0; age <= '0;
    end else begin
      vh <= {vh[1:0], in_valid_i};
      eh <= {eh[1:0], veto_en_i};
      zh <= {zh[1:0], (occ_i == '0)};
      if (age != 2'd3) age <= age + 2'd1;
    end
  end
  assign warm = (age == 2'd3);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid_o == vh[2]));

  p_veto_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && trig_o) |-> eh[2]);

  p_trig_in_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> out_valid_o);

  p_occ_zero_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid_o && zh[2] && eh[2]) |-> trig_o);

  always_comb
    if (!rst_n) begin
      a_reset_quiet_r11: assert (!out_valid_o && !trig_o);
    end
endmodule

bind ratio_window_subtrig ratio_window_subtrig_chk #(.OCC_W(OCC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .occ_i(occ_i),
  .veto_en_i(veto_en_i), .out_valid_o(out_valid_o), .trig_o(trig_o)
);

// File: tb/ratio_window_subtrig_tb_top.sv
module ratio_window_subtrig_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11, DW = 18, TW = 18, FRAC = 8, OW = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, veto_en = 1'b0;
  logic signed [DW-1:0] ref_v;
  logic [N*DW-1:0] coef_f;
  logic [N*TW-1:0] lo_f, hi_f;
  logic [OW-1:0] occ;
  logic out_valid, trig;

  logic signed [DW-1:0] cf [N];
  logic signed [TW-1:0] tl [N], th [N];

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ratio_window_subtrig dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .ref_i(ref_v),
    .coef_i(coef_f), .thr_lo_i(lo_f), .thr_hi_i(hi_f), .occ_i(occ),
    .veto_en_i(veto_en), .out_valid_o(out_valid), .trig_o(trig)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic int model_hits();
    int n = 0;
    for (int k = 0; k < N; k++) begin
      longint c = longint'(cf[k]) * (longint'(1) << FRAC);
      longint lo = longint'(ref_v) * longint'(tl[k]);
      longint hi = longint'(ref_v) * longint'(th[k]);
      if (c > lo && c < hi) n++;
    end
    return n;
  endfunction

  function automatic logic model_trig(int o, logic ve);
    return ve && (model_hits() >= o);
  endfunction

  task automatic pack();
    for (int k = 0; k < N; k++) begin
      coef_f[k*DW +: DW] = cf[k];
      lo_f[k*TW +: TW] = tl[k];
      hi_f[k*TW +: TW] = th[k];
    end
  endtask

  task automatic send(string req, int o, logic ve);
    logic exp;
    pack();
    occ = OW'(o); veto_en = ve; in_valid = 1'b1;
    exp = model_trig(o, ve);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid not yet"}, out_valid, 1'b0);
    @(negedge clk);
    check({req, " R2 valid"}, out_valid, 1'b1);
    check(req, trig, exp);
    @(negedge clk);
    check({req, " R6 idle"}, trig, 1'b0);
  endtask

  task automatic setup_unit(logic signed [DW-1:0] c, logic signed [TW-1:0] l, logic signed [TW-1:0] h);
    ref_v = DW'(1 << FRAC);
    for (int k = 0; k < N; k++) begin cf[k] = c; tl[k] = l; th[k] = h; end
  endtask

  task automatic t_reset();
    check("R11 valid in reset", out_valid, 1'b0);
    check("R11 trig in reset", trig, 1'b0);
  endtask

  task automatic t_all_pass();
    setup_unit(18'sd500, 18'sd100, 18'sd1000);
    send("R1 all inside occ11", 11, 1'b1);
    check("R1 model count", logic'(model_hits() == 11), 1'b1);
  endtask

  task automatic t_bounds();
    setup_unit(18'sd500, 18'sd100, 18'sd1000);
    cf[0] = 18'sd100; cf[1] = 18'sd1000; cf[2] = 18'sd101; cf[3] = 18'sd999;
    send("R3 R4 edges excluded occ10", 10, 1'b1);
    send("R3 R4 edges excluded occ9", 9, 1'b1);
    setup_unit(18'sd100, 18'sd100, 18'sd1000);
    send("R3 lower edge only occ1", 1, 1'b1);
    setup_unit(18'sd1000, 18'sd100, 18'sd1000);
    send("R4 upper edge only occ1", 1, 1'b1);
  endtask

  task automatic t_occ();
    setup_unit(18'sd500, 18'sd100, 18'sd1000);
    for (int k = 0; k < 5; k++) cf[k] = 18'sd5;
    send("R8 count6 occ6", 6, 1'b1);
    send("R8 count6 occ7", 7, 1'b1);
    send("R8 count6 occ15", 15, 1'b1);
    setup_unit(18'sd5, 18'sd100, 18'sd1000);
    send("R7 occ0 no hits", 0, 1'b1);
  endtask

  task automatic t_veto();
    setup_unit(18'sd500, 18'sd100, 18'sd1000);
    send("R5 veto low", 0, 1'b0);
    send("R5 veto low full count", 11, 1'b0);
  endtask

  task automatic t_signed();
    setup_unit(18'sd0, 18'sd0, 18'sd0);
    ref_v = -18'sd512;
    for (int k = 0; k < N; k++) begin tl[k] = -18'sd10; th[k] = -18'sd20; end
    cf[0] = 18'sd30; cf[1] = 18'sd21; cf[2] = 18'sd20; cf[3] = -18'sd30; cf[4] = 18'sd39;
    send("R9 negative ref count", 3, 1'b1);
    send("R9 negative ref count+1", 4, 1'b1);
  endtask

  task automatic t_stream();
    logic exp [4];
    setup_unit(18'sd500, 18'sd100, 18'sd1000);
    for (int k = 0; k < 4; k++) cf[k] = -18'sd7;
    pack();
    for (int i = 0; i < 7; i++) begin
      if (i >= 3) begin
        check("R10 stream valid", out_valid, 1'b1);
        check("R10 stream trig", trig, exp[i-3]);
      end
      if (i < 4) begin
        occ = OW'(6 + i); veto_en = (i != 1); in_valid = 1'b1;
        exp[i] = model_trig(6 + i, i != 1);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check("R10 stream drained", out_valid, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    ref_v = '0; coef_f = '0; lo_f = '0; hi_f = '0; occ = '0;
    for (int k = 0; k < N; k++) begin cf[k] = '0; tl[k] = '0; th[k] = '0; end
    in_valid = 1'b1; veto_en = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 idle after reset", trig, 1'b0);
    t_all_pass();
    t_bounds();
    t_occ();
    t_veto();
    t_signed();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule